// File: doc/BRIEF.md
# Ramp-Compare Analogue Position Timer

The block measures the position of three potentiometers by timing. An external voltage ramp restarts at each vertical sync. A comparator for each input goes high once the ramp passes the input's voltage. The block watches the three comparator outputs. On the first line of a field where a channel's comparator rises, it raises a pending interrupt for that channel. It also latches the vertical line count present at that moment, so the host can read the position later and still get the correct value.

After that trip, the channel ignores its comparator until the next vertical sync re-arms it. The host therefore sees at most one interrupt per channel per field. Pending bits stay set until the host clears them with an acknowledge write.

A slave-mode control bit comes from a general purpose register. When it is set, the block flips an analogue multiplexer select at every vertical sync, so the local and remote potentiometer sets are sampled on alternate fields. Each latched count also records which set was selected when it was captured.

Top module: `pot_ramp_timer`

## Requirements
- R1: After reset, all pending bits, `irq_o`, every latched line count and every source bit are 0, and `mux_sel_o` is 0 (local set).
- R2: Before the first vertical-sync rising edge after reset, no channel is armed, so a comparator rise sets no pending bit.
- R3: For an armed channel, a rising edge of its comparator sets its pending bit and latches the value of `line_i` at that time into the channel's field of `lat_line_o`. Bits `[i*LINE_W +: LINE_W]` hold channel i.
- R4: Once a channel has tripped, further comparator edges in the same field do not set its pending bit again and do not change its latched count.
- R5: A pending bit stays set across later fields. It clears only on a cycle with `ack_we_i`=1 and the matching `ack_mask_i` bit set; a write whose mask does not include that bit leaves it set.
- R6: If a trip and an acknowledge of the same channel take effect on the same cycle, the pending bit ends up set.
- R7: `irq_o` is 1 exactly when at least one pending bit is set.
- R8: At each rising edge of `vsync_i`, `mux_sel_o` inverts if `slave_en_i` is 1 and becomes 0 if it is 0. `mux_sel_o` does not change at any other time (0 = local set, 1 = remote set).
- R9: For each channel, `lat_src_o` records the value `mux_sel_o` had when that channel's count was latched.
- R10: A channel whose comparator does not rise during a field raises no interrupt and keeps its previous latched count. It is re-armed at the next vertical sync and trips normally in that field.
- R11: A `vsync_i` level held high for several cycles counts as one vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync level; its rising edge starts a field |
| slave_en_i | input | 1 | Slave mode: alternate the multiplexer select on each field |
| line_i | input | LINE_W | Current vertical line count |
| cmp_i | input | NCH | Raw comparator outputs, one per channel |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_mask_i | input | NCH | Pending bits to clear on an acknowledge write |
| irq_o | output | 1 | Interrupt request, OR of all pending bits |
| pend_o | output | NCH | Pending interrupt bit per channel |
| lat_line_o | output | NCH*LINE_W | Latched line count per channel |
| lat_src_o | output | NCH | Input set (0 local, 1 remote) of each latched count |
| mux_sel_o | output | 1 | Analogue multiplexer select |

## Verification
The assertions run on every cycle and cover the following:
- A pending bit rises only on a channel that was armed.
- A pending bit falls only on an acknowledge.
- A channel's latched count stays unchanged while the channel is disarmed.
- The multiplexer select moves only at a vertical-sync edge, inverting in slave mode and returning to local otherwise.

The bench scenarios cover what needs a whole field to show:
- that the latched value equals the line on which the input tripped;
- that a channel which never trips keeps its old count;
- that the source bit follows the alternating fields;
- that a long sync pulse counts as one field;
- that a trip coinciding with an acknowledge is not lost.

// File: rtl/pot_timer_pkg.sv
package pot_timer_pkg;
  typedef enum logic {
    SRC_LOCAL  = 1'b0,
    SRC_REMOTE = 1'b1
  } pot_src_e;
endpackage

// File: rtl/pot_edge_sync.sv
module pot_edge_sync #(
  parameter int NCH         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] cmp_i,
  output logic [NCH-1:0] rise_o
);
  localparam int LastIdx = SYNC_STAGES;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // stages 0..SYNC_STAGES-1 synchronise, the last one is the edge history
    logic [LastIdx:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[LastIdx-1:0], cmp_i[g]};
    end
    assign rise_o[g] = sh_q[LastIdx-1] & ~sh_q[LastIdx];
  end
endmodule

// File: rtl/pot_field_ctrl.sv
module pot_field_ctrl
  import pot_timer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     vsync_i,
  input  logic     slave_en_i,
  output logic     vs_rise_o,
  output pot_src_e mux_sel_o
);
  logic     vs_q;
  pot_src_e sel_q;

  assign vs_rise_o = vsync_i & ~vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q  <= 1'b0;
      sel_q <= SRC_LOCAL;
    end else begin
      vs_q <= vsync_i;
      if (vs_rise_o) sel_q <= slave_en_i ? pot_src_e'(~sel_q) : SRC_LOCAL;
    end
  end

  assign mux_sel_o = sel_q;

  // R8
  sel_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_rise_o && slave_en_i) |=> (sel_q != $past(sel_q)));
  // R8
  sel_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_rise_o && !slave_en_i) |=> (sel_q == SRC_LOCAL));
  // R8
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_rise_o |=> $stable(sel_q));
endmodule

// File: rtl/pot_chan.sv
module pot_chan
  import pot_timer_pkg::*;
#(
  parameter int LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vs_rise_i,
  input  logic              rise_i,
  input  logic              ack_i,
  input  logic [LINE_W-1:0] line_i,
  input  pot_src_e          src_i,
  output logic              pend_o,
  output logic [LINE_W-1:0] line_o,
  output pot_src_e          src_o
);
  logic              armed_q, pend_q, trip;
  logic [LINE_W-1:0] line_q;
  pot_src_e          src_q;

  // an edge in the arming cycle belongs to the old field and is dropped
  assign trip = armed_q & rise_i & ~vs_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      line_q  <= '0;
      src_q   <= SRC_LOCAL;
    end else begin
      if (vs_rise_i) armed_q <= 1'b1;
      else if (trip) armed_q <= 1'b0;
      if (trip)       pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
      if (trip) begin
        line_q <= line_i;
        src_q  <= src_i;
      end
    end
  end

  assign pend_o = pend_q;
  assign line_o = line_q;
  assign src_o  = src_q;

  // R4
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(armed_q));
  // R5
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(ack_i));
  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q) |=> $stable(line_q));
endmodule

// File: rtl/pot_ramp_timer.sv
module pot_ramp_timer
  import pot_timer_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int LINE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vsync_i,
  input  logic                  slave_en_i,
  input  logic [LINE_W-1:0]     line_i,
  input  logic [NCH-1:0]        cmp_i,
  input  logic                  ack_we_i,
  input  logic [NCH-1:0]        ack_mask_i,
  output logic                  irq_o,
  output logic [NCH-1:0]        pend_o,
  output logic [NCH*LINE_W-1:0] lat_line_o,
  output logic [NCH-1:0]        lat_src_o,
  output logic                  mux_sel_o
);
  logic           vs_rise;
  pot_src_e       sel;
  logic [NCH-1:0] rise;

  pot_field_ctrl u_field (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vsync_i    (vsync_i),
    .slave_en_i (slave_en_i),
    .vs_rise_o  (vs_rise),
    .mux_sel_o  (sel)
  );

  pot_edge_sync #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_i  (cmp_i),
    .rise_o (rise)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pot_src_e src;
    pot_chan #(.LINE_W(LINE_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .vs_rise_i (vs_rise),
      .rise_i    (rise[g]),
      .ack_i     (ack_we_i & ack_mask_i[g]),
      .line_i    (line_i),
      .src_i     (sel),
      .pend_o    (pend_o[g]),
      .line_o    (lat_line_o[g*LINE_W +: LINE_W]),
      .src_o     (src)
    );
    assign lat_src_o[g] = src;
  end

  assign irq_o     = |pend_o;
  assign mux_sel_o = sel;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (pend_o == '0 || !rst_ni));
endmodule

// File: tb/tb_pot_ramp_timer.sv
module tb_pot_ramp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int LW  = 9;
  localparam int NV  = 6;
  localparam int V_SLV [NV] = '{0, 0, 1, 1, 1, 0};
  localparam int V_TRIP [NV][NCH] = '{'{10, 20, 30}, '{5, 0, 39}, '{12, 12, 3},
                                      '{7, 25, 0}, '{33, 1, 18}, '{2, 3, 4}};

  logic clk = 0, rst_n = 0, vsync = 0, slave_en = 0, ack_we = 0;
  logic [LW-1:0] line = '0;
  logic [NCH-1:0] cmp = '0, ack_mask = '0;
  logic irq, mux_sel;
  logic [NCH-1:0] pend, src;
  logic [NCH*LW-1:0] lat;

  int checks = 0, fails = 0;
  bit done = 0;
  logic sel_m = 0;
  logic [NCH-1:0] pend_m = '0, src_m = '0;
  int lat_m [NCH] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  pot_ramp_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .slave_en_i(slave_en),
    .line_i(line), .cmp_i(cmp), .ack_we_i(ack_we), .ack_mask_i(ack_mask),
    .irq_o(irq), .pend_o(pend), .lat_line_o(lat), .lat_src_o(src),
    .mux_sel_o(mux_sel));

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic vs_pulse(int hold);
    cmp = '0;
    line = '0;
    vsync = 1;
    step(hold);
    vsync = 0;
    step(1);
    sel_m = slave_en ? ~sel_m : 1'b0;
  endtask

  task automatic check_all(string req);
    chk({req, " pend"}, int'(pend), int'(pend_m));
    chk("R7 irq", int'(irq), int'(pend_m != 0));
    for (int c = 0; c < NCH; c++) begin
      chk({req, " lat"}, int'(lat[c*LW +: LW]), lat_m[c]);
      chk("R9 src", int'(src[c]), int'(src_m[c]));
    end
  endtask

  initial begin
    step(2);
    // R1
    chk("R1 pend", int'(pend), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 sel", int'(mux_sel), 0);
    chk("R1 lat", int'(lat), 0);
    chk("R1 src", int'(src), 0);
    rst_n = 1;
    step(1);
    // R2: not armed before first sync
    line = 7; cmp = 3'b111;
    step(6);
    chk("R2 pend", int'(pend), 0);

    // Table walk: one field per vector
    for (int v = 0; v < NV; v++) begin
      slave_en = V_SLV[v][0];
      vs_pulse(2);
      chk("R8 sel", int'(mux_sel), int'(sel_m));
      for (int ln = 1; ln <= 40; ln++) begin
        line = LW'(ln);
        for (int c = 0; c < NCH; c++) if (V_TRIP[v][c] == ln) cmp[c] = 1'b1;
        step(4);
      end
      for (int c = 0; c < NCH; c++) if (V_TRIP[v][c] != 0) begin
        pend_m[c] = 1'b1; lat_m[c] = V_TRIP[v][c]; src_m[c] = sel_m;
      end
      check_all("R3 R10");
      ack_we = 1; ack_mask = 3'b001;
      step(1);
      ack_we = 0;
      pend_m[0] = 1'b0;
      chk("R5 partial ack", int'(pend), int'(pend_m));
      ack_we = 1; ack_mask = 3'b111;
      step(1);
      ack_we = 0;
      pend_m = '0;
      chk("R5 full ack", int'(pend), 0);
      chk("R7 irq low", int'(irq), 0);
    end

    // R4: second edge in same field ignored
    slave_en = 0;
    vs_pulse(1);
    line = 10; cmp[0] = 1; step(4);
    line = 11; cmp[0] = 0; step(4);
    line = 12; cmp[0] = 1; step(4);
    chk("R4 pend", int'(pend), 1);
    chk("R4 lat", int'(lat[0 +: LW]), 10);
    // R5: pending survives a new field without ack
    vs_pulse(1);
    chk("R5 held", int'(pend[0]), 1);
    // R6: trip and ack collide, set wins
    line = 20; cmp[1] = 1;
    step(2);
    ack_we = 1; ack_mask = 3'b010;
    step(1);
    ack_we = 0;
    step(2);
    chk("R6 pend", int'(pend[1]), 1);
    chk("R6 lat", int'(lat[LW +: LW]), 20);
    // R11: long sync counts once
    ack_we = 1; ack_mask = 3'b111; step(1); ack_we = 0;
    slave_en = 1;
    vs_pulse(6);
    chk("R11 sel", int'(mux_sel), int'(sel_m));
    vs_pulse(3);
    chk("R11 sel again", int'(mux_sel), int'(sel_m));
    // R8: leaving slave mode returns select to local
    slave_en = 0;
    vs_pulse(1);
    chk("R8 local", int'(mux_sel), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule